// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block is the configuration access path of a legacy I/O controller. It sits on a byte-wide, port-mapped bus and answers at two addresses. The index port sits at the base address and the data port at base plus one. Software first writes a register number to the index port. It then reads or writes that register through the data port.

Access is guarded by a key sequence. After reset the port is locked. It opens only when the unlock byte 0x87 is written to the index port twice in a row. Writing 0xAA to the index port locks it again. While the port is open, the low register space is decoded locally:

- a logical-device select register;
- read-only device identification, revision and vendor identification bytes.

Every index from 0x30 upward is passed to the selected logical device. This uses a simple address / write-data / read-data / strobe interface, and the device at the far end is a generic register file.

The base address is a parameter, so one instance can sit at 0x2E and another at 0x4E.

Top module: `keyed_cfg_port`

## Requirements
- R1: After reset the port is locked, `ld_sel` is 0x00, `io_rdata` is 0xFF, and no strobe is active.
- R2: While locked:
  - a read of either port returns 0xFF;
  - a data-port write changes nothing: no `ld_wr`, and `ld_sel` is unchanged;
  - an index-port write only feeds the key sequence and is never stored as an index.
- R3: Two back-to-back index-port writes of 0x87 open the port. After that, an index-port write stores the byte as the current index, and an index-port read returns it.
- R4: A single 0x87 followed by any other index-port byte returns the key sequence to locked. Opening then again needs two fresh consecutive 0x87 writes.
- R5: While open, an index-port write of 0xAA locks the port and does not change the stored index.
- R6: While open, index 0x07 is the logical-device select register. A data-port write loads it, a data-port read returns it, and its value drives `ld_sel` from the next clock edge.
- R7: While open, indices 0x20/0x21 read the device ID as high byte then low byte, and index 0x22 reads the revision. Indices 0x23/0x24 read the vendor ID 0x1934 as high byte then low byte. Data-port writes to these indices are ignored.
- R8: While open, a data-port access to an index of 0x30 or above is forwarded to the logical device:
  - in the same cycle, `ld_addr` equals the index;
  - a write pulses `ld_wr` with `ld_wdata`;
  - a read pulses `ld_rd`, and the `ld_rdata` of that cycle appears on `io_rdata` after the next clock edge.
- R9: While open, indices below 0x30 other than those in R6 and R7 read 0x00. Accesses to them raise no strobe.
- R10: Accesses to any address other than base and base+1 are ignored. `io_rdata` is 0xFF in every cycle that does not follow a read of one of the two ports.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 16 | Port address of the current bus cycle |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid the cycle after a read; 0xFF otherwise |
| ld_sel | output | 8 | Selected logical-device number |
| ld_addr | output | 8 | Forwarded register index |
| ld_wdata | output | 8 | Forwarded write data |
| ld_wr | output | 1 | Forwarded write strobe |
| ld_rd | output | 1 | Forwarded read strobe |
| ld_rdata | input | 8 | Read data returned by the logical device in the strobe cycle |

## Verification
The forwarding strobes `ld_wr` and `ld_rd` follow the bus access in the same cycle. They are counted at the rising edge that closes that access. Read data and the `ld_sel` value both become visible one edge after the access. The bench therefore drives each access at a falling edge and waits through the next rising edge. It samples `io_rdata` and `ld_sel` at the falling edge after that, before it drives the next access. A bench-side model of the key sequence, the index, the select register and a mirror of the device register file predicts every read value, the `ld_sel` value and the strobe counts. This covers directed key-sequence corner cases and a seeded random mix of accesses.

// File: rtl/cfgport_pkg.sv
// Shared types and fixed index map for the keyed configuration port.
package cfgport_pkg;
    typedef enum logic [1:0] {
        KS_LOCKED = 2'd0,
        KS_HALF   = 2'd1,
        KS_OPEN   = 2'd2
    } key_state_t;

    localparam logic [7:0] IDX_LDSEL  = 8'h07;
    localparam logic [7:0] IDX_DEV_HI = 8'h20;
    localparam logic [7:0] IDX_DEV_LO = 8'h21;
    localparam logic [7:0] IDX_REV    = 8'h22;
    localparam logic [7:0] IDX_VEN_HI = 8'h23;
    localparam logic [7:0] IDX_VEN_LO = 8'h24;
endpackage

// File: rtl/cfgport_keyfsm.sv
// Key sequencer: tracks unlock/lock bytes written to the index port.
// Assumes idx_wr is a one-cycle strobe of an index-port write.
module cfgport_keyfsm #(
    parameter int          DW         = 8,
    parameter logic [DW-1:0] UNLOCK_KEY = 8'h87,
    parameter logic [DW-1:0] LOCK_KEY   = 8'hAA
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          idx_wr,
    input  logic [DW-1:0] wdata,
    output logic          open,
    output logic          idx_load
);
    import cfgport_pkg::*;

    key_state_t state_q, state_d;

    // Next-state decode of the key sequence
    always_comb begin
        state_d  = state_q;
        idx_load = 1'b0;
        if (idx_wr) begin
            unique case (state_q)
                KS_LOCKED: if (wdata == UNLOCK_KEY) state_d = KS_HALF;
                KS_HALF:   state_d = (wdata == UNLOCK_KEY) ? KS_OPEN : KS_LOCKED;
                KS_OPEN: begin
                    if (wdata == LOCK_KEY) state_d = KS_LOCKED;
                    else                   idx_load = 1'b1;
                end
                default:   state_d = KS_LOCKED;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= KS_LOCKED;
        else        state_q <= state_d;
    end

    assign open = (state_q == KS_OPEN);
endmodule

// File: rtl/cfgport_globals.sv
// Global register space: index register, logical-device select and
// read-only identification bytes. Assumes strobes are already qualified
// by port address and, for data writes, by the open state.
module cfgport_globals #(
    parameter int            DW      = 8,
    parameter logic [15:0]   DEV_ID  = 16'h1010,
    parameter logic [DW-1:0] REV     = 8'h01,
    parameter logic [15:0]   VEN_ID  = 16'h1934
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          idx_load,
    input  logic          dat_wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] index,
    output logic [DW-1:0] ld_sel,
    output logic [DW-1:0] glob_rdata
);
    import cfgport_pkg::*;

    // Index register, loaded only from an open-state index write
    always_ff @(posedge clk) begin
        if (!rst_n)        index <= '0;
        else if (idx_load) index <= wdata;
    end

    // Logical-device select register
    always_ff @(posedge clk) begin
        if (!rst_n)                               ld_sel <= '0;
        else if (dat_wr && index == IDX_LDSEL)    ld_sel <= wdata;
    end

    // Read decode of the local indices
    always_comb begin
        unique case (index)
            IDX_LDSEL:  glob_rdata = ld_sel;
            IDX_DEV_HI: glob_rdata = DEV_ID[15:8];
            IDX_DEV_LO: glob_rdata = DEV_ID[7:0];
            IDX_REV:    glob_rdata = REV;
            IDX_VEN_HI: glob_rdata = VEN_ID[15:8];
            IDX_VEN_LO: glob_rdata = VEN_ID[7:0];
            default:    glob_rdata = '0;
        endcase
    end
endmodule

// File: rtl/cfgport_fwd.sv
// Forwarder: passes data-port accesses at or above FWD_START to the
// selected logical device. Assumes strobes are qualified by open state.
module cfgport_fwd #(
    parameter int            DW        = 8,
    parameter logic [DW-1:0] FWD_START = 8'h30
) (
    input  logic          dat_wr,
    input  logic          dat_rd,
    input  logic [DW-1:0] index,
    input  logic [DW-1:0] wdata,
    output logic          fwd_hit,
    output logic [DW-1:0] ld_addr,
    output logic [DW-1:0] ld_wdata,
    output logic          ld_wr,
    output logic          ld_rd
);
    // Range decode and strobe generation
    always_comb begin
        fwd_hit  = (index >= FWD_START);
        ld_addr  = index;
        ld_wdata = wdata;
        ld_wr    = dat_wr && fwd_hit;
        ld_rd    = dat_rd && fwd_hit;
    end
endmodule

// File: rtl/keyed_cfg_port.sv
// Keyed index/data configuration port. Index port at BASE_ADDR, data
// port at BASE_ADDR+1. Assumes one-cycle io_wr/io_rd strobes, never
// both in the same cycle. Read data is registered: valid one cycle
// after io_rd, 0xFF otherwise.
module keyed_cfg_port #(
    parameter int              AW         = 16,
    parameter int              DW         = 8,
    parameter logic [AW-1:0]   BASE_ADDR  = 16'h002E,
    parameter logic [DW-1:0]   UNLOCK_KEY = 8'h87,
    parameter logic [DW-1:0]   LOCK_KEY   = 8'hAA,
    parameter logic [DW-1:0]   FWD_START  = 8'h30,
    parameter logic [15:0]     DEV_ID     = 16'h1010,
    parameter logic [DW-1:0]   REV        = 8'h01,
    parameter logic [15:0]     VEN_ID     = 16'h1934
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] io_addr,
    input  logic          io_wr,
    input  logic          io_rd,
    input  logic [DW-1:0] io_wdata,
    output logic [DW-1:0] io_rdata,
    output logic [DW-1:0] ld_sel,
    output logic [DW-1:0] ld_addr,
    output logic [DW-1:0] ld_wdata,
    output logic          ld_wr,
    output logic          ld_rd,
    input  logic [DW-1:0] ld_rdata
);
    localparam logic [AW-1:0] DATA_ADDR = BASE_ADDR + 1'b1;
    localparam logic [DW-1:0] IDLE_DATA = '1;

    logic          hit_idx, hit_dat;
    logic          open, idx_load, dat_wr, dat_rd, fwd_hit;
    logic [DW-1:0] index, glob_rdata;

    // Port address decode and open-state qualification
    always_comb begin
        hit_idx = (io_addr == BASE_ADDR);
        hit_dat = (io_addr == DATA_ADDR);
        dat_wr  = io_wr && hit_dat && open;
        dat_rd  = io_rd && hit_dat && open;
    end

    cfgport_keyfsm #(.DW(DW), .UNLOCK_KEY(UNLOCK_KEY), .LOCK_KEY(LOCK_KEY)) u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (io_wr && hit_idx),
        .wdata    (io_wdata),
        .open     (open),
        .idx_load (idx_load)
    );

    cfgport_globals #(.DW(DW), .DEV_ID(DEV_ID), .REV(REV), .VEN_ID(VEN_ID)) u_glob (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx_load   (idx_load),
        .dat_wr     (dat_wr),
        .wdata      (io_wdata),
        .index      (index),
        .ld_sel     (ld_sel),
        .glob_rdata (glob_rdata)
    );

    cfgport_fwd #(.DW(DW), .FWD_START(FWD_START)) u_fwd (
        .dat_wr   (dat_wr),
        .dat_rd   (dat_rd),
        .index    (index),
        .wdata    (io_wdata),
        .fwd_hit  (fwd_hit),
        .ld_addr  (ld_addr),
        .ld_wdata (ld_wdata),
        .ld_wr    (ld_wr),
        .ld_rd    (ld_rd)
    );

    // Registered read-data return
    always_ff @(posedge clk) begin
        if (!rst_n)                    io_rdata <= IDLE_DATA;
        else if (io_rd && hit_idx)     io_rdata <= open ? index : IDLE_DATA;
        else if (dat_rd)               io_rdata <= fwd_hit ? ld_rdata : glob_rdata;
        else                           io_rdata <= IDLE_DATA;
    end
endmodule

// File: rtl/keyed_cfg_port_chk.sv
// Property checker for keyed_cfg_port, attached by bind.
module keyed_cfg_port_chk #(
    parameter int            AW        = 16,
    parameter int            DW        = 8,
    parameter logic [AW-1:0] BASE_ADDR = 16'h002E,
    parameter logic [DW-1:0] FWD_START = 8'h30,
    parameter logic [DW-1:0] UNLOCK_KEY = 8'h87
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] io_addr,
    input logic          io_wr,
    input logic          io_rd,
    input logic [DW-1:0] io_wdata,
    input logic [DW-1:0] io_rdata,
    input logic [DW-1:0] ld_sel,
    input logic [DW-1:0] ld_addr,
    input logic          ld_wr,
    input logic          ld_rd,
    input logic          open
);
    logic past_ok = 1'b0;
    always_ff @(posedge clk) past_ok <= rst_n;

    // R2: no forwarding strobe while locked
    p_locked_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !open |-> (!ld_wr && !ld_rd));

    // R8: forwarded writes come only from data-port writes in range
    p_fwd_wr_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ld_wr |-> (io_wr && io_addr == BASE_ADDR + 1'b1 && ld_addr >= FWD_START));

    // R3: the port opens only right after an unlock byte on the index port
    p_open_key_r3: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        $rose(open) |-> ($past(io_wr) && $past(io_addr) == BASE_ADDR
                         && $past(io_wdata) == UNLOCK_KEY));

    // R6: select register holds unless a data-port write occurs
    p_ldsel_hold_r6: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        !(io_wr && io_addr == BASE_ADDR + 1'b1) |=> $stable(ld_sel));

    // R10: idle read data is all ones
    p_rdata_idle_r10: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        !io_rd |=> (io_rdata == '1));
endmodule

bind keyed_cfg_port keyed_cfg_port_chk #(
    .AW(AW), .DW(DW), .BASE_ADDR(BASE_ADDR), .FWD_START(FWD_START), .UNLOCK_KEY(UNLOCK_KEY)
) u_chk (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .ld_sel(ld_sel), .ld_addr(ld_addr),
    .ld_wr(ld_wr), .ld_rd(ld_rd), .open(open)
);

// File: tb/tb_keyed_cfg_port.sv
module tb_keyed_cfg_port;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] BASE = 16'h002E;
    localparam logic [15:0] DATP = 16'h002F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata, ld_sel, ld_addr, ld_wdata, ld_rdata;
    logic        ld_wr, ld_rd;

    keyed_cfg_port dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .ld_sel(ld_sel), .ld_addr(ld_addr),
        .ld_wdata(ld_wdata), .ld_wr(ld_wr), .ld_rd(ld_rd), .ld_rdata(ld_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Logical-device register file attached at the forwarding interface
    logic [7:0] dev_mem [256];
    assign ld_rdata = dev_mem[ld_addr];
    int wr_cnt = 0, rd_cnt = 0;
    always @(posedge clk) begin
        if (ld_wr) begin dev_mem[ld_addr] <= ld_wdata; wr_cnt <= wr_cnt + 1; end
        if (ld_rd) rd_cnt <= rd_cnt + 1;
    end

    // Bench model
    int         m_state = 0;     // 0 locked, 1 half, 2 open
    logic [7:0] m_idx = 8'h00, m_sel = 8'h00;
    logic [7:0] exp_mem [256];
    int         exp_wr = 0, exp_rd = 0;
    int         n_chk = 0, n_bad = 0;
    bit         done = 0;

    function automatic logic [7:0] exp_data(logic [7:0] idx);
        if (m_state != 2) return 8'hFF;
        case (idx)
            8'h07: return m_sel;
            8'h20: return 8'h10;
            8'h21: return 8'h10;
            8'h22: return 8'h01;
            8'h23: return 8'h19;
            8'h24: return 8'h34;
            default: return (idx >= 8'h30) ? exp_mem[idx] : 8'h00;
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One bus access; returns io_rdata sampled one edge later
    task automatic access(logic [15:0] a, bit w, bit r, logic [7:0] d, output logic [7:0] q);
        io_addr = a; io_wr = w; io_rd = r; io_wdata = d;
        @(posedge clk); @(negedge clk);
        io_wr = 0; io_rd = 0;
        q = io_rdata;
    endtask

    // Model update for an index-port write
    task automatic m_idx_wr(logic [7:0] d);
        case (m_state)
            0: if (d == 8'h87) m_state = 1;
            1: m_state = (d == 8'h87) ? 2 : 0;
            default: if (d == 8'hAA) m_state = 0; else m_idx = d;
        endcase
    endtask

    task automatic m_dat_wr(logic [7:0] d);
        if (m_state == 2) begin
            if (m_idx == 8'h07) m_sel = d;
            else if (m_idx >= 8'h30) begin exp_mem[m_idx] = d; exp_wr++; end
        end
    endtask

    task automatic iw(logic [7:0] d);
        logic [7:0] q; access(BASE, 1, 0, d, q); m_idx_wr(d);
    endtask
    task automatic dw(logic [7:0] d);
        logic [7:0] q; access(DATP, 1, 0, d, q); m_dat_wr(d);
    endtask
    task automatic dr(string req);
        logic [7:0] q, e;
        e = exp_data(m_idx);
        if (m_state == 2 && m_idx >= 8'h30) exp_rd++;
        access(DATP, 0, 1, 8'h00, q);
        check(req, q, e);
    endtask
    task automatic ir(string req);
        logic [7:0] q;
        access(BASE, 0, 1, 8'h00, q);
        check(req, q, (m_state == 2) ? m_idx : 8'hFF);
    endtask

    initial begin
        #(CLK_PERIOD*150000);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] q;
        int unused_seed;
        unused_seed = $urandom(32'h00C0FFEE);
        for (int i = 0; i < 256; i++) begin
            dev_mem[i] = 8'(i) ^ 8'h5A;
            exp_mem[i] = 8'(i) ^ 8'h5A;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 rdata", io_rdata, 8'hFF);
        check("R1 ld_sel", ld_sel, 8'h00);
        check("R1 strobes", {ld_wr, ld_rd}, 2'b00);

        // R2 locked behaviour
        dr("R2 locked data read");
        ir("R2 locked index read");
        iw(8'h07); dw(8'h55);
        check("R2 ld_sel unchanged", ld_sel, 8'h00);
        check("R2 no ld_wr", wr_cnt, 0);

        // R4 broken key pair
        iw(8'h87); iw(8'h12); iw(8'h87);
        ir("R4 still locked");
        // R3 second consecutive key opens
        iw(8'h87);
        iw(8'h07);
        ir("R3 index readback");

        // R6 select register
        dw(8'h06);
        check("R6 ld_sel", ld_sel, 8'h06);
        dr("R6 select readback");

        // R7 identification bytes
        for (int k = 0; k < 5; k++) begin
            iw(8'h20 + 8'(k)); dr("R7 id byte");
        end
        iw(8'h23); dw(8'h00); dr("R7 write ignored");

        // R9 unused local index
        iw(8'h10); dw(8'h77); dr("R9 reads zero");
        check("R9 no strobe", wr_cnt + rd_cnt, 0);

        // R8 forwarding
        iw(8'h30); dw(8'hC3);
        check("R8 ld_wr count", wr_cnt, 1);
        dr("R8 forwarded read");
        check("R8 ld_rd count", rd_cnt, 1);
        iw(8'hFF); dr("R8 top index read");

        // R10 foreign address ignored
        access(BASE + 16'd2, 1, 0, 8'hAA, q);
        check("R10 idle rdata", q, 8'hFF);
        access(BASE + 16'd2, 0, 1, 8'h00, q);
        check("R10 foreign read", q, 8'hFF);
        ir("R10 still open");

        // R5 lock byte
        iw(8'hAA);
        dr("R5 locked after AA");
        iw(8'h87); iw(8'h87);
        ir("R5 index kept");

        // Random mix
        for (int n = 0; n < 3000; n++) begin
            int op, pick;
            logic [7:0] b;
            op = $urandom % 8;
            pick = $urandom % 8;
            case (pick)
                0, 1: b = 8'h87;
                2: b = 8'hAA;
                3: b = 8'h07;
                4: b = 8'h20 + 8'($urandom % 5);
                5: b = 8'h30 + 8'($urandom % 16);
                6: b = 8'($urandom);
                default: b = 8'h10;
            endcase
            case (op)
                0, 1: iw(b);
                2: dw(8'($urandom));
                3, 4: dr("R8 random data read");
                5: ir("R3 random index read");
                6: begin access(BASE + 16'd5, 1, 0, b, q); check("R10 random foreign", q, 8'hFF); end
                default: begin iw(8'h87); iw(8'h87); end
            endcase
            check("R6 random ld_sel", ld_sel, m_sel);
        end
        check("R8 total writes", wr_cnt, exp_wr);
        check("R8 total reads", rd_cnt, exp_rd);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule